// File: doc/BRIEF.md
# Fetch-Decode-Execute Sequencer

This block is the control unit of a small stored-program machine. It owns the program counter, the instruction fields, a single working register and a three-bit condition register. It drives a byte-wide memory port to fetch each instruction and then to carry it out. Each instruction is an 8-bit opcode followed by zero, one or two 8-bit memory addresses. The sequencer reads the opcode and any address bytes, advancing the program counter past each byte it reads. It then executes the instruction using memory reads and writes, a small adder and a magnitude comparator. When it is done it fetches the next instruction. A halt instruction, or any opcode it does not recognise, parks the block until reset.

The memory port has a one-cycle read latency. If the block asserts `mem_rd` with `mem_addr` in one cycle, `mem_rdata` holds that byte in the next cycle. A write happens at the clock edge while `mem_wr` is high.

The states are `ST_FETCH_OP`, `ST_GET_OP`, `ST_FETCH_A1`, `ST_GET_A1`, `ST_FETCH_A2`, `ST_GET_A2`, `ST_EXEC`, `ST_READ_X`, `ST_GET_X`, `ST_READ_Y`, `ST_GET_Y`, `ST_PUT_Y` and `ST_HALTED`. Each fetch state is followed by its get state. The transitions out of the get and execute states are:

- **After the opcode:** `ST_GET_OP` goes to `ST_HALTED` for a zero-address opcode, and to `ST_FETCH_A1` otherwise.
- **After the first address:** `ST_GET_A1` goes to `ST_FETCH_A2` for a two-address opcode, and to `ST_EXEC` otherwise.
- **After the second address:** `ST_GET_A2` goes to `ST_EXEC`.
- **Execute:** `ST_EXEC` completes store and jump instructions and returns to `ST_FETCH_OP`. For load, move, add and compare it goes to `ST_READ_X`.
- **After reading X:**
  - `ST_GET_X` returns to `ST_FETCH_OP` after a load.
  - It goes to `ST_PUT_Y` after a move.
  - It goes to `ST_READ_Y` after an add or a compare.
- **Final steps:** `ST_GET_Y` writes the sum or updates the condition bits, and `ST_PUT_Y` writes the moved byte. Both return to `ST_FETCH_OP`.

Top module: `fde_sequencer`

## Requirements
- R1: While reset is low the block reports pc=0, all three condition bits 0 and halted=0. In the first cycle after reset it issues a read of address 0.
- R2: The opcode and each address byte are read from the address held in pc. The pc advances by one for each byte read, so HALT occupies 1 byte, LOAD, STORE and the four jumps occupy 2 bytes, and MOVE, ADD and COMPARE occupy 3 bytes.
- R3: LOAD X (opcode 2) copies memory byte X into the working register `acc`. STORE X (opcode 3) writes `acc` into memory byte X.
- R4: MOVE X,Y (opcode 4) writes the byte at X into Y and leaves X unchanged.
- R5: ADD X,Y (opcode 9) writes (X+Y) mod 256 into Y. This also holds when X and Y are the same address.
- R6: COMPARE X,Y (opcode 1) sets exactly one condition bit: gt when X>Y, eq when X=Y, lt when X<Y. The other two bits are cleared, including any bits a previous compare left set.
- R7: JUMP X (opcode 5) loads pc with X, so the next opcode is fetched from X.
- R8: JUMPGT (6), JUMPEQ (7) and JUMPLT (8) load pc with X only when gt, eq or lt respectively is 1. Otherwise execution continues with the next instruction.
- R9: HALT (opcode 0) and every opcode from 10 to 255 set halted. Once halted, the block issues no further reads or writes, pc stays fixed, and halted stays high until reset.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address (copy of pc during fetches) |
| mem_rd | output | 1 | Read request; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| acc | output | 8 | Working register |
| pc | output | 8 | Program counter |
| cond_gt | output | 1 | Greater-than condition bit |
| cond_eq | output | 1 | Equal condition bit |
| cond_lt | output | 1 | Less-than condition bit |
| halted | output | 1 | High once a halt or unknown opcode has been fetched |

## Verification
The bench runs two compares back to back. A register that ORs new condition bits into old ones would then show both gt and lt. It also checks compare results with equal operands, and an ADD whose sum wraps past 255. A design that dropped the carry wrongly, or read Y before X, would leave the wrong byte in memory.

Branches are tested both taken and not taken for each condition. Wrong fall-through lengths show up as markers written to the wrong address, or as a wrong final pc. Opcode 10, the first undefined value, must halt with pc just past it and leave the memory port quiet. A design that decoded it as a two-address instruction would keep fetching and storing.

// File: rtl/fde_pkg.sv
package fde_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_HALT = 8'd0;
    localparam logic [OPC_W-1:0] OPC_CMP  = 8'd1;
    localparam logic [OPC_W-1:0] OPC_LOAD = 8'd2;
    localparam logic [OPC_W-1:0] OPC_STOR = 8'd3;
    localparam logic [OPC_W-1:0] OPC_MOVE = 8'd4;
    localparam logic [OPC_W-1:0] OPC_JMP  = 8'd5;
    localparam logic [OPC_W-1:0] OPC_JGT  = 8'd6;
    localparam logic [OPC_W-1:0] OPC_JEQ  = 8'd7;
    localparam logic [OPC_W-1:0] OPC_JLT  = 8'd8;
    localparam logic [OPC_W-1:0] OPC_ADD  = 8'd9;

    typedef enum logic [3:0] {
        K_HALT, K_LOAD, K_STORE, K_MOVE, K_ADD, K_CMP,
        K_JMP, K_JGT, K_JEQ, K_JLT
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [1:0] n_addr;
    } dec_t;

    typedef enum logic [3:0] {
        ST_FETCH_OP, ST_GET_OP,
        ST_FETCH_A1, ST_GET_A1,
        ST_FETCH_A2, ST_GET_A2,
        ST_EXEC,
        ST_READ_X, ST_GET_X,
        ST_READ_Y, ST_GET_Y,
        ST_PUT_Y,
        ST_HALTED
    } seq_state_e;

endpackage

// File: rtl/fde_decode.sv
module fde_decode
    import fde_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] opcode,
    output dec_t              dec
);
    always_comb begin
        dec = '{kind: K_HALT, n_addr: 2'd0};
        unique case (opcode)
            WORD_W'(OPC_LOAD): dec = '{kind: K_LOAD,  n_addr: 2'd1};
            WORD_W'(OPC_STOR): dec = '{kind: K_STORE, n_addr: 2'd1};
            WORD_W'(OPC_JMP):  dec = '{kind: K_JMP,   n_addr: 2'd1};
            WORD_W'(OPC_JGT):  dec = '{kind: K_JGT,   n_addr: 2'd1};
            WORD_W'(OPC_JEQ):  dec = '{kind: K_JEQ,   n_addr: 2'd1};
            WORD_W'(OPC_JLT):  dec = '{kind: K_JLT,   n_addr: 2'd1};
            WORD_W'(OPC_MOVE): dec = '{kind: K_MOVE,  n_addr: 2'd2};
            WORD_W'(OPC_ADD):  dec = '{kind: K_ADD,   n_addr: 2'd2};
            WORD_W'(OPC_CMP):  dec = '{kind: K_CMP,   n_addr: 2'd2};
            default:           dec = '{kind: K_HALT,  n_addr: 2'd0};
        endcase
    end
endmodule

// File: rtl/fde_alu.sv
module fde_alu #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] lhs,
    input  logic [WORD_W-1:0] rhs,
    output logic [WORD_W-1:0] sum,
    output logic              is_gt,
    output logic              is_eq,
    output logic              is_lt
);
    always_comb begin
        sum   = lhs + rhs;
        is_gt = lhs > rhs;
        is_eq = lhs == rhs;
        is_lt = lhs < rhs;
    end
endmodule

// File: rtl/fde_ccr.sv
module fde_ccr (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic gt_in,
    input  logic eq_in,
    input  logic lt_in,
    output logic gt_q,
    output logic eq_q,
    output logic lt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gt_q <= 1'b0;
            eq_q <= 1'b0;
            lt_q <= 1'b0;
        end else if (upd) begin
            gt_q <= gt_in;
            eq_q <= eq_in;
            lt_q <= lt_in;
        end
    end
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
    import fde_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] pc,
    output logic              cond_gt,
    output logic              cond_eq,
    output logic              cond_lt,
    output logic              halted
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    seq_state_e        state, state_nx;
    logic [WORD_W-1:0] ir_op, a1, a2, tmp;
    logic [WORD_W-1:0] dec_in, sum;
    dec_t              dec;
    logic              alu_gt, alu_eq, alu_lt;
    logic              ccr_upd, taken;

    assign dec_in = (state == ST_GET_OP) ? mem_rdata : ir_op;

    fde_decode #(.WORD_W(WORD_W)) u_dec (.opcode(dec_in), .dec(dec));

    fde_alu #(.WORD_W(WORD_W)) u_alu (
        .lhs(tmp), .rhs(mem_rdata), .sum(sum),
        .is_gt(alu_gt), .is_eq(alu_eq), .is_lt(alu_lt)
    );

    fde_ccr u_ccr (
        .clk(clk), .rst_n(rst_n), .upd(ccr_upd),
        .gt_in(alu_gt), .eq_in(alu_eq), .lt_in(alu_lt),
        .gt_q(cond_gt), .eq_q(cond_eq), .lt_q(cond_lt)
    );

    always_comb begin
        unique case (dec.kind)
            K_JMP:   taken = 1'b1;
            K_JGT:   taken = cond_gt;
            K_JEQ:   taken = cond_eq;
            K_JLT:   taken = cond_lt;
            default: taken = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH_OP;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_OP: state_nx = ST_GET_OP;
            ST_GET_OP:   state_nx = (dec.n_addr == 2'd0) ? ST_HALTED : ST_FETCH_A1;
            ST_FETCH_A1: state_nx = ST_GET_A1;
            ST_GET_A1:   state_nx = (dec.n_addr == 2'd2) ? ST_FETCH_A2 : ST_EXEC;
            ST_FETCH_A2: state_nx = ST_GET_A2;
            ST_GET_A2:   state_nx = ST_EXEC;
            ST_EXEC: begin
                unique case (dec.kind)
                    K_LOAD, K_MOVE, K_ADD, K_CMP: state_nx = ST_READ_X;
                    default:                      state_nx = ST_FETCH_OP;
                endcase
            end
            ST_READ_X:   state_nx = ST_GET_X;
            ST_GET_X: begin
                unique case (dec.kind)
                    K_LOAD:  state_nx = ST_FETCH_OP;
                    K_MOVE:  state_nx = ST_PUT_Y;
                    default: state_nx = ST_READ_Y;
                endcase
            end
            ST_READ_Y:   state_nx = ST_GET_Y;
            ST_GET_Y:    state_nx = ST_FETCH_OP;
            ST_PUT_Y:    state_nx = ST_FETCH_OP;
            ST_HALTED:   state_nx = ST_HALTED;
            default:     state_nx = ST_HALTED;
        endcase
    end

    // decoded strobes
    always_comb begin
        mem_addr  = pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = acc;
        ccr_upd   = 1'b0;
        unique case (state)
            ST_FETCH_OP, ST_FETCH_A1, ST_FETCH_A2: mem_rd = 1'b1;
            ST_EXEC: begin
                if (dec.kind == K_STORE) begin
                    mem_addr = a1;
                    mem_wr   = 1'b1;
                end
            end
            ST_READ_X: begin
                mem_addr = a1;
                mem_rd   = 1'b1;
            end
            ST_READ_Y: begin
                mem_addr = a2;
                mem_rd   = 1'b1;
            end
            ST_GET_Y: begin
                mem_addr = a2;
                if (dec.kind == K_ADD) begin
                    mem_wr    = 1'b1;
                    mem_wdata = sum;
                end else begin
                    ccr_upd = 1'b1;
                end
            end
            ST_PUT_Y: begin
                mem_addr  = a2;
                mem_wr    = 1'b1;
                mem_wdata = tmp;
            end
            default: ;
        endcase
    end

    assign halted = (state == ST_HALTED);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            ir_op <= '0;
            a1    <= '0;
            a2    <= '0;
            tmp   <= '0;
            acc   <= '0;
        end else begin
            unique case (state)
                ST_GET_OP: begin
                    ir_op <= mem_rdata;
                    pc    <= pc + ONE;
                end
                ST_GET_A1: begin
                    a1 <= mem_rdata;
                    pc <= pc + ONE;
                end
                ST_GET_A2: begin
                    a2 <= mem_rdata;
                    pc <= pc + ONE;
                end
                ST_EXEC: if (taken) pc <= a1;
                ST_GET_X: begin
                    if (dec.kind == K_LOAD) acc <= mem_rdata;
                    else                    tmp <= mem_rdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted,
    input logic              cond_gt,
    input logic              cond_eq,
    input logic              cond_lt,
    input logic [WORD_W-1:0] pc
);
    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    p_halt_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cond_gt, cond_eq, cond_lt}));
endmodule

bind fde_sequencer fde_sequencer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .halted(halted), .cond_gt(cond_gt), .cond_eq(cond_eq),
    .cond_lt(cond_lt), .pc(pc)
);

// File: tb/fde_sequencer_bench.sv
`timescale 1ns/1ps
module fde_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, acc, pc;
    logic [7:0] mem_rdata = '0;
    logic       mem_rd, mem_wr, cond_gt, cond_eq, cond_lt, halted;

    logic [7:0] mem [256];
    logic       clr = 1'b0, ld_en = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fde_sequencer u_fde_sequencer (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc(acc), .pc(pc), .cond_gt(cond_gt), .cond_eq(cond_eq),
        .cond_lt(cond_lt), .halted(halted)
    );

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        clr   = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic poke(input int a, input int d);
        ld_en   = 1'b1;
        ld_addr = 8'(a);
        ld_data = 8'(d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int cyc;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " halted"}, int'(halted), 1);
    endtask

    task automatic test_transfer();
        begin_prog();
        poke(100, 8'h5A);
        poke(0, 2); poke(1, 100);
        poke(2, 3); poke(3, 101);
        poke(4, 4); poke(5, 100); poke(6, 102);
        poke(7, 0);
        run_to_halt("R3");
        chk("R3 acc after LOAD", int'(acc), 8'h5A);
        chk("R3 STORE target", int'(mem[101]), 8'h5A);
        chk("R4 MOVE target", int'(mem[102]), 8'h5A);
        chk("R4 MOVE source kept", int'(mem[100]), 8'h5A);
        chk("R2 pc after 2+2+3+1 bytes", int'(pc), 8);
    endtask

    task automatic test_add();
        begin_prog();
        poke(100, 200); poke(101, 100); poke(102, 7);
        poke(0, 9); poke(1, 100); poke(2, 101);
        poke(3, 9); poke(4, 102); poke(5, 102);
        poke(6, 0);
        run_to_halt("R5");
        chk("R5 ADD wraps", int'(mem[101]), 44);
        chk("R5 ADD same address", int'(mem[102]), 14);
        chk("R5 ADD X unchanged", int'(mem[100]), 200);
        chk("R2 pc after ADD pair", int'(pc), 7);
    endtask

    task automatic test_compare();
        begin_prog();
        poke(200, 9); poke(201, 5);
        poke(0, 1); poke(1, 200); poke(2, 201);
        poke(3, 1); poke(4, 201); poke(5, 200);
        poke(6, 0);
        run_to_halt("R6");
        chk("R6 lt after gt then lt", int'({cond_gt, cond_eq, cond_lt}), 3'b001);
        chk("R2 pc after two COMPAREs", int'(pc), 7);
        begin_prog();
        poke(200, 7);
        poke(0, 1); poke(1, 200); poke(2, 200);
        poke(3, 0);
        run_to_halt("R6");
        chk("R6 eq on equal operands", int'({cond_gt, cond_eq, cond_lt}), 3'b010);
    endtask

    task automatic test_reset();
        begin_prog();
        repeat (2) @(negedge clk);
        chk("R1 pc in reset", int'(pc), 0);
        chk("R1 flags in reset", int'({cond_gt, cond_eq, cond_lt}), 0);
        chk("R1 halted in reset", int'(halted), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 first read", int'(mem_rd), 1);
        chk("R1 first address", int'(mem_addr), 0);
        run_to_halt("R9");
        chk("R2 pc after HALT", int'(pc), 1);
    endtask

    task automatic test_jump();
        begin_prog();
        poke(200, 8'h11);
        poke(0, 2); poke(1, 200);
        poke(2, 5); poke(3, 8);
        poke(4, 3); poke(5, 150);
        poke(6, 0);
        poke(8, 3); poke(9, 151);
        poke(10, 0);
        run_to_halt("R7");
        chk("R7 skipped store", int'(mem[150]), 0);
        chk("R7 target store", int'(mem[151]), 8'h11);
        chk("R7 pc", int'(pc), 11);
    endtask

    task automatic test_branch(input int x, input int y, input int nt1,
                               input int nt2, input int tk);
        begin_prog();
        poke(200, x); poke(201, y);
        poke(0, 1); poke(1, 200); poke(2, 201);
        poke(3, nt1); poke(4, 30);
        poke(5, nt2); poke(6, 30);
        poke(7, tk); poke(8, 20);
        poke(9, 2); poke(10, 200); poke(11, 3); poke(12, 150); poke(13, 0);
        poke(20, 2); poke(21, 200); poke(22, 3); poke(23, 151); poke(24, 0);
        poke(30, 2); poke(31, 200); poke(32, 3); poke(33, 152); poke(34, 0);
        run_to_halt("R8");
        chk($sformatf("R8 taken op %0d", tk), int'(mem[151]), x);
        chk($sformatf("R8 fell past op %0d", tk), int'(mem[150]), 0);
        chk($sformatf("R8 not-taken ops %0d/%0d", nt1, nt2), int'(mem[152]), 0);
        chk("R8 pc", int'(pc), 25);
    endtask

    task automatic test_unknown();
        int busy;
        logic [7:0] pc_h;
        begin_prog();
        poke(200, 8'h33);
        poke(0, 2); poke(1, 200);
        poke(2, 10);
        poke(3, 3); poke(4, 150);
        poke(5, 0);
        run_to_halt("R9");
        chk("R9 pc past unknown opcode", int'(pc), 3);
        chk("R9 acc", int'(acc), 8'h33);
        busy = 0;
        pc_h = pc;
        repeat (20) begin
            @(negedge clk);
            if (mem_rd || mem_wr) busy++;
        end
        chk("R9 port quiet", busy, 0);
        chk("R9 halted held", int'(halted), 1);
        chk("R9 pc held", int'(pc), int'(pc_h));
        chk("R9 no store after unknown", int'(mem[150]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        test_transfer();
        test_add();
        test_compare();
        test_reset();
        test_jump();
        test_branch(9, 5, 8, 7, 6);
        test_branch(3, 3, 6, 8, 7);
        test_branch(5, 9, 6, 7, 8);
        test_unknown();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule